// File: doc/BRIEF.md
# Stereo PDM Sinc3 Decimator

The block receives a two-microphone pulse-density bitstream that shares one data wire. It produces the microphone clock from the system clock with a fixed divider. It samples the shared wire once per microphone-clock edge and forms two 1-bit streams. The right stream is taken at each rising edge and the left stream at each falling edge, so each stream runs at half the microphone clock rate. Each stream feeds its own third-order cascaded integrator-comb decimator. The decimator maps bit 1 to +1 and bit 0 to -1. It has three integrators at the bit rate, a rate reduction by R, and three combs at the output rate. It uses adders and subtractors only. The result is a pair of signed PCM samples with one valid strobe per channel.

R is chosen at run time as 64 or 128. The choice is latched only while the block is disabled or at the boundary of an output sample, so a change never shortens or stretches the frame in progress. While the block is enabled the microphone clock toggles without pause. Disabling it parks the clock low and clears all filter history, and the next enable restarts the filter from a zero history.

Top module: `pdm_stereo_cic`

## Requirements
- R1: `pdmClk` is low during reset and whenever `enable` is low. While `enable` is high it toggles once every `HALF_DIV` system cycles, and its first rise comes `HALF_DIV` cycles after enable.
- R2: The value of `pdmData` at the system clock edge where `pdmClk` rises is the next right-channel bit. The value at the edge where `pdmClk` falls is the next left-channel bit.
- R3: A data bit of 1 enters the filter as +1 and a bit of 0 enters it as -1.
- R4: Each output sample equals the input stream convolved with the sinc3 kernel, which is three length-R boxcars convolved together (length 3R-2), with all history before enable taken as zero. The output includes the bits up to and including the edge that completes the frame.
- R5: One output pair appears every R falling edges of `pdmClk`. `leftValid` and `rightValid` are one-cycle pulses on the same cycle, which is the cycle right after the completing falling edge.
- R6: `decimSel` = 0 selects R = 64 and `decimSel` = 1 selects R = 128. At the default ratio-64 setting the spacing between output pairs is 64·2·`HALF_DIV` system cycles.
- R7: Output samples are `5+3*LOG_R_LO` bits wide in two's complement, and integrator overflow wraps harmlessly. A constant 1 stream yields exactly +R³ from the third output on, and a constant 0 stream yields exactly -R³.
- R8: A change of `decimSel` while enabled does not alter the frame in progress. The new ratio applies from the frame after the next output.
- R9: Dropping `enable` clears the divider, the frame counter and both filters. After re-enable, outputs match a filter started from zero history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the microphone clock and the filters |
| decimSel | input | 1 | Ratio select: 0 gives 64, 1 gives 128 |
| pdmData | input | 1 | Shared microphone data line |
| pdmClk | output | 1 | Generated microphone clock |
| leftPcm | output | 5+3*LOG_R_LO | Left PCM sample, signed |
| rightPcm | output | 5+3*LOG_R_LO | Right PCM sample, signed |
| leftValid | output | 1 | Left sample strobe |
| rightValid | output | 1 | Right sample strobe |

## Verification
The bench builds the block with `HALF_DIV` = 3 and `LOG_R_LO` = 6. The odd divider exercises a counter limit that is not a power of two. Both ratios, 64 and 128, produce outputs within a few thousand cycles. A ratio-128 full-scale stream reaches +2²¹ and -2²¹, which tests the top of the 23-bit word and the wrap-around of the integrators. The reference model pushes ±1 values into per-channel queues and convolves them with a sinc3 kernel computed at start-up. It runs a mid-frame ratio change to show that frames are never cut short, and a disable followed by re-enable to show that history is cleared.

// File: rtl/pdm_cic_pkg.sv
package pdm_cic_pkg;
  // Strobes from the control to the datapath, all single-cycle
  typedef struct packed {
    logic riseStb;   // pdmClk rises at this edge: right bit is taken
    logic fallStb;   // pdmClk falls at this edge: left bit is taken
    logic dumpStb;   // this falling edge completes an output frame
    logic clear;     // block disabled: wipe all history
  } pdmCtl_t;
endpackage

// File: rtl/pdm_cic_ctrl.sv
module pdm_cic_ctrl
  import pdm_cic_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int LOG_R_LO = 6
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    decimSel,
  output logic    pdmClk,
  output pdmCtl_t ctl
);
  localparam int DIV_W    = $clog2(HALF_DIV);
  localparam int LOG_R_HI = LOG_R_LO + 1;
  localparam logic [DIV_W-1:0]    DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [LOG_R_HI-1:0] LAST_LO  = LOG_R_HI'((1 << LOG_R_LO) - 1);
  localparam logic [LOG_R_HI-1:0] LAST_HI  = '1;

  logic [DIV_W-1:0]    divCnt;
  logic [LOG_R_HI-1:0] pairCnt;
  logic                activeSel;
  logic                tick;
  logic                pairLast;

  assign tick     = enable && (divCnt == DIV_LAST);
  assign pairLast = (pairCnt == (activeSel ? LAST_HI : LAST_LO));

  always_comb begin
    ctl.clear   = !enable;
    ctl.riseStb = tick && !pdmClk;
    ctl.fallStb = tick && pdmClk;
    ctl.dumpStb = tick && pdmClk && pairLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt    <= '0;
      pdmClk    <= 1'b0;
      pairCnt   <= '0;
      activeSel <= 1'b0;
    end else if (!enable) begin
      divCnt    <= '0;
      pdmClk    <= 1'b0;
      pairCnt   <= '0;
      activeSel <= decimSel;
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) pdmClk <= !pdmClk;
      if (ctl.fallStb) pairCnt <= pairLast ? '0 : pairCnt + 1'b1;
      if (ctl.dumpStb) activeSel <= decimSel;
    end
  end
endmodule

// File: rtl/pdm_cic_sinc3.sv
module pdm_cic_sinc3 #(
  parameter int ACC_W = 23
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clear,
  input  logic                    bitStb,
  input  logic                    bitVal,
  input  logic                    dumpStb,
  output logic signed [ACC_W-1:0] pcm,
  output logic                    valid
);
  localparam int ORDER = 3;

  logic signed [ACC_W-1:0] integ     [ORDER];
  logic signed [ACC_W-1:0] integNext [ORDER];
  logic signed [ACC_W-1:0] combDly   [ORDER];
  logic signed [ACC_W-1:0] stage     [ORDER+1];
  logic signed [ACC_W-1:0] inVal;

  // Integrators chain on this cycle's sums; overflow wraps modulo 2^ACC_W.
  always_comb begin
    inVal = bitVal ? ACC_W'(1) : '1;
    integNext[0] = bitStb ? integ[0] + inVal : integ[0];
    for (int k = 1; k < ORDER; k++)
      integNext[k] = bitStb ? integ[k] + integNext[k-1] : integ[k];
    stage[0] = integNext[ORDER-1];
    for (int k = 0; k < ORDER; k++)
      stage[k+1] = stage[k] - combDly[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < ORDER; k++) begin
        integ[k]   <= '0;
        combDly[k] <= '0;
      end
      pcm   <= '0;
      valid <= 1'b0;
    end else if (clear) begin
      for (int k = 0; k < ORDER; k++) begin
        integ[k]   <= '0;
        combDly[k] <= '0;
      end
      pcm   <= '0;
      valid <= 1'b0;
    end else begin
      for (int k = 0; k < ORDER; k++) integ[k] <= integNext[k];
      if (dumpStb) begin
        for (int k = 0; k < ORDER; k++) combDly[k] <= stage[k];
        pcm <= stage[ORDER];
      end
      valid <= dumpStb;
    end
  end
endmodule

// File: rtl/pdm_cic_datapath.sv
module pdm_cic_datapath
  import pdm_cic_pkg::*;
#(
  parameter int ACC_W = 23
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    pdmData,
  input  pdmCtl_t                 ctl,
  output logic signed [ACC_W-1:0] leftPcm,
  output logic signed [ACC_W-1:0] rightPcm,
  output logic                    leftValid,
  output logic                    rightValid
);
  localparam int N_CH = 2;  // index 0 = left (falling edge), 1 = right (rising edge)

  logic signed [ACC_W-1:0] pcmArr   [N_CH];
  logic                    validArr [N_CH];

  for (genvar g = 0; g < N_CH; g++) begin : gChan
    logic chStb;
    assign chStb = (g == 0) ? ctl.fallStb : ctl.riseStb;
    pdm_cic_sinc3 #(.ACC_W(ACC_W)) sinc3_i (
      .clk     (clk),
      .rstN    (rstN),
      .clear   (ctl.clear),
      .bitStb  (chStb),
      .bitVal  (pdmData),
      .dumpStb (ctl.dumpStb),
      .pcm     (pcmArr[g]),
      .valid   (validArr[g])
    );
  end

  assign leftPcm    = pcmArr[0];
  assign rightPcm   = pcmArr[1];
  assign leftValid  = validArr[0];
  assign rightValid = validArr[1];
endmodule

// File: rtl/pdm_stereo_cic.sv
module pdm_stereo_cic
  import pdm_cic_pkg::*;
#(
  parameter  int HALF_DIV = 4,
  parameter  int LOG_R_LO = 6,
  localparam int ACC_W    = 5 + 3 * LOG_R_LO
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic                    decimSel,
  input  logic                    pdmData,
  output logic                    pdmClk,
  output logic signed [ACC_W-1:0] leftPcm,
  output logic signed [ACC_W-1:0] rightPcm,
  output logic                    leftValid,
  output logic                    rightValid
);
  pdmCtl_t ctl;

  pdm_cic_ctrl #(.HALF_DIV(HALF_DIV), .LOG_R_LO(LOG_R_LO)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .decimSel (decimSel),
    .pdmClk   (pdmClk),
    .ctl      (ctl)
  );

  pdm_cic_datapath #(.ACC_W(ACC_W)) path_i (
    .clk        (clk),
    .rstN       (rstN),
    .pdmData    (pdmData),
    .ctl        (ctl),
    .leftPcm    (leftPcm),
    .rightPcm   (rightPcm),
    .leftValid  (leftValid),
    .rightValid (rightValid)
  );
endmodule

// File: rtl/pdm_stereo_cic_chk.sv
module pdm_stereo_cic_chk #(
  parameter int HALF_DIV = 4,
  parameter int LOG_R_LO = 6,
  parameter int ACC_W    = 23
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    enable,
  input logic                    pdmClk,
  input logic signed [ACC_W-1:0] leftPcm,
  input logic signed [ACC_W-1:0] rightPcm,
  input logic                    leftValid,
  input logic                    rightValid
);
  localparam int FULL = 1 << (3 * (LOG_R_LO + 1));

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !pdmClk);
  // R1
  clk_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (HALF_DIV > 1) && $rose(pdmClk) |=> $stable(pdmClk));
  // R5
  valid_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    leftValid == rightValid);
  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    leftValid |=> !leftValid);
  // R5
  valid_after_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    leftValid |-> $fell(pdmClk));
  // R7
  range_chk: assert property (@(posedge clk) disable iff (!rstN)
    leftValid |-> (int'(leftPcm) <= FULL && int'(leftPcm) >= -FULL &&
                   int'(rightPcm) <= FULL && int'(rightPcm) >= -FULL));
endmodule

bind pdm_stereo_cic pdm_stereo_cic_chk #(
  .HALF_DIV(HALF_DIV), .LOG_R_LO(LOG_R_LO), .ACC_W(ACC_W)
) chk_i (
  .clk(clk), .rstN(rstN), .enable(enable), .pdmClk(pdmClk),
  .leftPcm(leftPcm), .rightPcm(rightPcm),
  .leftValid(leftValid), .rightValid(rightValid)
);

// File: tb/pdm_stereo_cic_tb_top.sv
module pdm_stereo_cic_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HD   = 3;
  localparam int LLO  = 6;
  localparam int W    = 5 + 3 * LLO;
  localparam int KMAX = 3 * 128;

  logic clk = 1'b0, rstN = 1'b0, enable = 1'b0, decimSel = 1'b0, pdmData = 1'b0;
  logic pdmClk, leftValid, rightValid;
  logic signed [W-1:0] leftPcm, rightPcm;

  pdm_stereo_cic #(.HALF_DIV(HD), .LOG_R_LO(LLO)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .decimSel(decimSel),
    .pdmData(pdmData), .pdmClk(pdmClk), .leftPcm(leftPcm),
    .rightPcm(rightPcm), .leftValid(leftValid), .rightValid(rightValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // Stimulus controls
  int  mode = 0;           // 0 constant, 1 random, 2 left=1/right=0
  bit  constVal = 1'b1;
  bit  enReq = 1'b0, selReq = 1'b0, rstReq = 1'b0;

  // Reference model state
  int  mCnt = 0, mPairs = 0;
  bit  mClk = 0, mSel = 0, expValid = 0, valOk = 1;
  int  expL = 0, expR = 0;
  int  leftQ[$], rightQ[$];
  int  kern[2][KMAX];
  int  lastL = 0, lastR = 0, prevValidCyc = -1, lastGap = 0;
  int  gaps[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic buildKernels();
    for (int s = 0; s < 2; s++) begin
      int r = (s == 0) ? 64 : 128;
      for (int j = 0; j < KMAX; j++) begin
        int acc = 0;
        for (int a = 0; a < r; a++) begin
          int t = j - a;
          if (t >= 0 && t < 2*r - 1) acc += (t + 1 < 2*r - 1 - t) ? t + 1 : 2*r - 1 - t;
        end
        kern[s][j] = acc;
      end
    end
  endtask

  function automatic int convolve(ref int q[$], input bit sel);
    int r = sel ? 128 : 64;
    int acc = 0;
    for (int j = 0; j < 3*r - 2; j++) begin
      int idx = q.size() - 1 - j;
      if (idx >= 0) acc += kern[sel][j] * q[idx];
    end
    return acc;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      // compare outputs of the previous posedge
      chk(pdmClk === mClk, "R1", pdmClk, mClk);
      chk(leftValid === expValid, "R5", leftValid, expValid);
      chk(rightValid === expValid, "R5", rightValid, expValid);
      if (expValid && valOk) begin
        chk(int'(leftPcm) == expL, "R4", int'(leftPcm), expL);
        chk(int'(rightPcm) == expR, "R4", int'(rightPcm), expR);
      end
      if (leftValid) begin
        lastL = int'(leftPcm);
        lastR = int'(rightPcm);
        if (prevValidCyc >= 0) begin
          lastGap = cyc - prevValidCyc;
          gaps.push_back(lastGap);
        end
        prevValidCyc = cyc;
      end
      // drive inputs for the next posedge
      rstN     = !rstReq;
      enable   = enReq;
      decimSel = selReq;
      case (mode)
        0: pdmData = constVal;
        1: pdmData = 1'($urandom % 2);
        default: pdmData = mClk;  // rising edge (clk low) gets 0, falling gets 1
      endcase
      // model the next posedge
      expValid = 0;
      if (rstReq) begin
        mCnt = 0; mClk = 0; mPairs = 0; mSel = 0; valOk = 1;
        leftQ.delete(); rightQ.delete(); prevValidCyc = -1;
      end else if (!enable) begin
        mCnt = 0; mClk = 0; mPairs = 0; mSel = decimSel; valOk = 1;
        leftQ.delete(); rightQ.delete(); prevValidCyc = -1;
      end else if (mCnt == HD - 1) begin
        mCnt = 0;
        if (!mClk) begin
          rightQ.push_back(pdmData ? 1 : -1);
          mClk = 1;
        end else begin
          leftQ.push_back(pdmData ? 1 : -1);
          mClk = 0;
          mPairs++;
          if (mPairs == (mSel ? 128 : 64)) begin
            mPairs = 0;
            expValid = 1;
            expL = convolve(leftQ, mSel);
            expR = convolve(rightQ, mSel);
            if (decimSel != mSel) valOk = 0;  // mixed-ratio history: timing only
            mSel = decimSel;
          end
        end
      end else begin
        mCnt++;
      end
    end
  endtask

  initial begin
    buildKernels();
    rstReq = 1;
    step(5);
    // R1: reset state
    chk(pdmClk === 1'b0, "R1", pdmClk, 0);
    chk(leftValid === 1'b0 && rightValid === 1'b0, "R5", leftValid, 0);
    rstReq = 0;
    step(3);

    // Ratio 64, constant ones: R3/R6/R7
    selReq = 0; mode = 0; constVal = 1; enReq = 1;
    step(1700);
    chk(lastL == 262144, "R7", lastL, 262144);
    chk(lastR == 262144, "R3", lastR, 262144);
    chk(lastGap == 64*2*HD, "R6", lastGap, 64*2*HD);

    // Disable: clock parks low, history cleared (R9)
    enReq = 0;
    step(10);
    chk(pdmClk === 1'b0, "R9", pdmClk, 0);

    // Ratio 128, constant zeros after a restart: R7/R9/R6
    selReq = 1; constVal = 0; enReq = 1;
    step(3300);
    chk(lastL == -2097152, "R7", lastL, -2097152);
    chk(lastR == -2097152, "R9", lastR, -2097152);
    chk(lastGap == 128*2*HD, "R6", lastGap, 128*2*HD);

    // Random stream at ratio 128: R4 on every output via the model
    mode = 1;
    step(5000);

    // Channel separation: left ones, right zeros (R2)
    enReq = 0; step(4);
    mode = 2; enReq = 1;
    step(3300);
    chk(lastL == 2097152, "R2", lastL, 2097152);
    chk(lastR == -2097152, "R2", lastR, -2097152);

    // Mid-frame ratio change (R8)
    enReq = 0; step(4);
    mode = 1; selReq = 1; enReq = 1;
    step(1000);
    gaps.delete();
    selReq = 0;
    step(2500);
    chk(gaps.size() >= 2, "R8", gaps.size(), 2);
    if (gaps.size() >= 2) begin
      chk(gaps[0] == 128*2*HD, "R8", gaps[0], 128*2*HD);
      chk(gaps[1] == 64*2*HD, "R8", gaps[1], 64*2*HD);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule